// File: doc/BRIEF.md
# Packed Decimal String Codec

This block turns a signed decimal number into a packed-decimal byte string, and turns such a string back into digits. On the encode side a command carries a digit count, a sign flag and a vector of 4-bit decimal digits. The block checks the command and then sends the string out one byte per cycle on a valid/ready stream. Each byte holds two digits. The final byte carries the sign code in its low nibble. When the count is even, a zero nibble is placed first so that the digits and the sign fill whole bytes.

On the decode side a byte stream with a last marker arrives on a valid/ready input. The block collects the bytes and presents one result holding the digit vector, the digit count, the sign and an error flag. Both paths follow the same back-pressure rules. A producer holds `valid` and its payload until the cycle in which `ready` is high. A transfer happens on a rising edge where both are high. While the block has output pending, its outputs do not change. The command input and the byte input are not ready while earlier output is still waiting to be taken.

Top module: `pdec_codec`

## Requirements
- R1: Digit index 0 of `enc_in_digits` (bits [3:0]) is the most significant digit. Digits are placed in order: the high nibble (bits [7:4]) of a byte before its low nibble (bits [3:0]), and earlier bytes before later bytes.
- R2: An odd count places digit 0 in the high nibble of the first byte. An even count makes that nibble 0 and shifts every digit by one nibble position.
- R3: A valid command produces exactly count/2+1 bytes (integer division), and `enc_out_last` is high only on the final one. A count of 0 gives a single byte holding a zero digit nibble and the sign.
- R4: The low nibble of the final byte is 4'hC when `enc_in_neg` is 0 and 4'hD when it is 1.
- R5: A command is rejected when its count is above 31 or when a digit at an index below the count is above 9. `enc_err` is then high for exactly the one cycle after acceptance, and no byte is sent. Digits at indices at or above the count are ignored, even if they are above 9.
- R6: While `enc_out_ready` is low, `enc_out_valid`, `enc_out_data` and `enc_out_last` hold their values. `enc_in_ready` is low until the final byte has been taken.
- R7: The decoder numbers the nibbles of the incoming string from 0 (high nibble of the first byte). Every nibble except the last becomes digit p at bits [4p+3:4p] of `dec_out_digits`. `dec_out_count` is 2*bytes-1, and digits above the count read 0. An even-count pad nibble comes back as a leading zero digit.
- R8: The decoder reads the sign nibble 4'hA, 4'hC, 4'hE or 4'hF as positive (`dec_out_neg`=0) and 4'hB or 4'hD as negative (`dec_out_neg`=1). Any other sign value sets `dec_out_err`.
- R9: A digit nibble above 9, or a string longer than 16 bytes, sets `dec_out_err`. With the error set, `dec_out_count` reads 0.
- R10: The decoder result holds while `dec_out_ready` is low, and `dec_in_ready` stays low until the result is taken.
- R11: The first encoded byte, or `enc_err`, is valid in the cycle after the command is accepted. The decode result is valid in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Encode command valid |
| enc_in_ready | output | 1 | Encoder can accept a command |
| enc_in_count | input | 6 | Number of digits (0 to 31 legal) |
| enc_in_neg | input | 1 | 1 for a negative number |
| enc_in_digits | input | 124 | Digit vector, index 0 most significant |
| enc_err | output | 1 | One-cycle pulse for a rejected command |
| enc_out_valid | output | 1 | Encoded byte valid |
| enc_out_ready | input | 1 | Downstream takes the byte |
| enc_out_data | output | 8 | Encoded byte |
| enc_out_last | output | 1 | Final (sign) byte of the string |
| dec_in_valid | input | 1 | Incoming packed byte valid |
| dec_in_ready | output | 1 | Decoder can take a byte |
| dec_in_data | input | 8 | Incoming packed byte |
| dec_in_last | input | 1 | Byte is the final (sign) byte |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_ready | input | 1 | Downstream takes the result |
| dec_out_digits | output | 124 | Decoded digits, index 0 most significant |
| dec_out_count | output | 6 | Decoded digit count |
| dec_out_neg | output | 1 | Decoded sign, 1 for negative |
| dec_out_err | output | 1 | Malformed string |

## Verification
An accepted command shows its first byte or its error pulse one cycle after the accepting edge. Each later byte appears on the cycle after the edge that took the previous one. The decode result appears one cycle after the edge that took the last byte. The bench drives inputs on falling edges and samples on the next falling edge. It checks each output exactly at the cycle it is due and never waits open-endedly for it, so a design that is early or late by one cycle fails the check. Stalls hold `ready` low for two sampled cycles and compare the held outputs with the values seen before.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam logic [3:0] SGN_POS = 4'hC;
  localparam logic [3:0] SGN_NEG = 4'hD;

  // returns {recognised, negative}
  function automatic logic [1:0] sign_kind(input logic [3:0] n);
    logic [1:0] r;
    case (n)
      4'hA, 4'hC, 4'hE, 4'hF: r = 2'b10;
      4'hB, 4'hD:             r = 2'b11;
      default:                r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pdec_enc.sv
module pdec_enc
  import pdec_pkg::*;
#(
  parameter int MAXD = 31,
  parameter int CW   = $clog2(MAXD + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CW-1:0]     in_count,
  input  logic              in_neg,
  input  logic [MAXD*4-1:0] in_digits,
  output logic              err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int IW = CW - 1;

  logic [MAXD-1:0]   lane_bad;
  logic              bad_cmd, accept;
  logic              busy_q, err_q, neg_q;
  logic [CW-1:0]     cnt_q;
  logic [MAXD*4-1:0] dig_q;
  logic [IW-1:0]     idx_q;

  // one range check per digit lane, live only below the count
  for (genvar g = 0; g < MAXD; g++) begin : g_lane
    assign lane_bad[g] = (CW'(g) < in_count) && (in_digits[g*4 +: 4] > 4'd9);
  end

  assign bad_cmd  = (in_count > CW'(MAXD)) || (|lane_bad);
  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      dig_q  <= '0;
      idx_q  <= '0;
    end else begin
      err_q <= accept && bad_cmd;
      if (accept && !bad_cmd) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        dig_q  <= in_digits;
        cnt_q  <= in_count;
        neg_q  <= in_neg;
      end else if (busy_q && out_ready) begin
        if (out_last) busy_q <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // nibble p of the padded string: optional zero pad, digits, then sign
  function automatic logic [3:0] nib_at(input int p, input logic [CW-1:0] c,
                                        input logic ng, input logic [MAXD*4-1:0] d);
    int pad;
    int q;
    logic [3:0] r;
    pad = c[0] ? 0 : 1;
    q   = p - pad;
    r   = ng ? SGN_NEG : SGN_POS;
    if (p < pad) r = 4'h0;
    else if (q < int'(c)) begin
      for (int i = 0; i < MAXD; i++)
        if (i == q) r = d[i*4 +: 4];
    end
    return r;
  endfunction

  always_comb begin
    out_data[7:4] = nib_at(2 * int'(idx_q),     cnt_q, neg_q, dig_q);
    out_data[3:0] = nib_at(2 * int'(idx_q) + 1, cnt_q, neg_q, dig_q);
  end

  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == cnt_q[CW-1:1]);
  assign err       = err_q;

  a_r6_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  a_r5_err_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
  a_r4_sign_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data[3:0] == SGN_POS || out_data[3:0] == SGN_NEG));
endmodule

// File: rtl/pdec_dec.sv
module pdec_dec
  import pdec_pkg::*;
#(
  parameter int MAXD = 31,
  parameter int CW   = $clog2(MAXD + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MAXD*4-1:0] out_digits,
  output logic [CW-1:0]     out_count,
  output logic              out_neg,
  output logic              out_err
);
  localparam int MAXB = MAXD / 2 + 1;
  localparam int KW   = CW - 1;

  logic              hold_q, err_q, neg_q, accept;
  logic [KW-1:0]     k_q;
  logic [CW-1:0]     cnt_q;
  logic [MAXD*4-1:0] nib_q, nib_d;
  logic [3:0]        hi, lo;
  logic [1:0]        sk;
  logic              fits_mid, fits_last, e_mid, e_last;

  assign in_ready  = !hold_q;
  assign accept    = in_valid && in_ready;
  assign hi        = in_data[7:4];
  assign lo        = in_data[3:0];
  assign sk        = sign_kind(lo);
  assign fits_mid  = k_q < KW'(MAXB - 1);
  assign fits_last = k_q < KW'(MAXB);
  assign e_mid     = (hi > 4'd9) || (lo > 4'd9) || !fits_mid;
  assign e_last    = (hi > 4'd9) || !sk[1] || !fits_last || err_q;

  // write the incoming nibbles into their digit slots
  always_comb begin
    nib_d = nib_q;
    for (int i = 0; i < MAXD; i++) begin
      if (i == 2 * int'(k_q)) nib_d[i*4 +: 4] = hi;
      if (!in_last && i == 2 * int'(k_q) + 1) nib_d[i*4 +: 4] = lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      err_q  <= 1'b0;
      neg_q  <= 1'b0;
      k_q    <= '0;
      cnt_q  <= '0;
      nib_q  <= '0;
    end else if (accept) begin
      nib_q <= nib_d;
      if (in_last) begin
        hold_q <= 1'b1;
        err_q  <= e_last;
        neg_q  <= sk[0];
        cnt_q  <= e_last ? '0 : CW'(2 * int'(k_q) + 1);
      end else begin
        err_q <= err_q || e_mid;
        if (fits_last) k_q <= k_q + 1'b1;
      end
    end else if (hold_q && out_ready) begin
      hold_q <= 1'b0;
      err_q  <= 1'b0;
      k_q    <= '0;
      nib_q  <= '0;
    end
  end

  assign out_valid  = hold_q;
  assign out_digits = nib_q;
  assign out_count  = cnt_q;
  assign out_neg    = neg_q;
  assign out_err    = err_q;

  a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digits) && $stable(out_count)
                                   && $stable(out_neg) && $stable(out_err)));
  a_r7_odd_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> out_count[0]);
  a_r9_err_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_count == '0));
endmodule

// File: rtl/pdec_codec.sv
module pdec_codec #(
  parameter int MAX_DIGITS = 31,
  parameter int CW         = $clog2(MAX_DIGITS + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_in_valid,
  output logic                    enc_in_ready,
  input  logic [CW-1:0]           enc_in_count,
  input  logic                    enc_in_neg,
  input  logic [MAX_DIGITS*4-1:0] enc_in_digits,
  output logic                    enc_err,
  output logic                    enc_out_valid,
  input  logic                    enc_out_ready,
  output logic [7:0]              enc_out_data,
  output logic                    enc_out_last,
  input  logic                    dec_in_valid,
  output logic                    dec_in_ready,
  input  logic [7:0]              dec_in_data,
  input  logic                    dec_in_last,
  output logic                    dec_out_valid,
  input  logic                    dec_out_ready,
  output logic [MAX_DIGITS*4-1:0] dec_out_digits,
  output logic [CW-1:0]           dec_out_count,
  output logic                    dec_out_neg,
  output logic                    dec_out_err
);
  pdec_enc #(.MAXD(MAX_DIGITS), .CW(CW)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready),
    .in_count(enc_in_count), .in_neg(enc_in_neg), .in_digits(enc_in_digits),
    .err(enc_err),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready),
    .out_data(enc_out_data), .out_last(enc_out_last)
  );

  pdec_dec #(.MAXD(MAX_DIGITS), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_data(dec_in_data), .in_last(dec_in_last),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready),
    .out_digits(dec_out_digits), .out_count(dec_out_count),
    .out_neg(dec_out_neg), .out_err(dec_out_err)
  );
endmodule

// File: tb/sim_pdec_codec.sv
module sim_pdec_codec;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_in_valid = 0, enc_in_neg = 0, enc_out_ready = 0;
  logic [5:0] enc_in_count = '0;
  logic [ND*4-1:0] enc_in_digits = '0;
  logic enc_in_ready, enc_err, enc_out_valid, enc_out_last;
  logic [7:0] enc_out_data;
  logic dec_in_valid = 0, dec_in_last = 0, dec_out_ready = 0;
  logic [7:0] dec_in_data = '0;
  logic dec_in_ready, dec_out_valid, dec_out_neg, dec_out_err;
  logic [ND*4-1:0] dec_out_digits;
  logic [5:0] dec_out_count;

  int checks = 0;
  int failures = 0;
  logic [7:0] dbuf [0:19];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pdec_codec u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkv(input string req, input string what, input logic [ND*4-1:0] act,
                      input logic [ND*4-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // encoder scenario: expected bytes built from the nibble rules
  task automatic enc_case(input string tag, input int cnt, input bit neg,
                          input logic [ND*4-1:0] dig, input bit stall);
    int nb, pad;
    logic [3:0] nibs [0:33];
    logic [7:0] exp_b [0:16];
    nb  = cnt / 2 + 1;
    pad = (cnt % 2 == 0) ? 1 : 0;
    for (int p = 0; p < 2 * nb; p++) begin
      if (p < pad) nibs[p] = 4'h0;
      else if (p - pad < cnt) nibs[p] = dig[(p - pad) * 4 +: 4];
      else nibs[p] = neg ? 4'hD : 4'hC;
    end
    for (int b = 0; b < nb; b++) exp_b[b] = {nibs[2*b], nibs[2*b+1]};
    @(negedge clk);
    chk("R6", "enc_in_ready idle", enc_in_ready, 1);
    enc_in_valid = 1; enc_in_count = 6'(cnt); enc_in_neg = neg; enc_in_digits = dig;
    @(negedge clk);
    enc_in_valid = 0; enc_in_digits = '1;
    chk("R11", "first byte due", enc_out_valid, 1);
    chk("R6", "enc_in_ready while sending", enc_in_ready, 0);
    if (stall) begin
      for (int s = 0; s < 2; s++) begin
        chk("R6", "stall valid", enc_out_valid, 1);
        chk("R6", "stall data", enc_out_data, exp_b[0]);
        @(negedge clk);
      end
    end
    for (int b = 0; b < nb; b++) begin
      chk(tag, $sformatf("byte %0d", b), enc_out_data, exp_b[b]);
      chk("R3", $sformatf("valid %0d", b), enc_out_valid, 1);
      chk("R3", $sformatf("last %0d", b), enc_out_last, (b == nb - 1) ? 1 : 0);
      if (b == nb - 1) chk("R4", "sign nibble", enc_out_data[3:0], neg ? 4'hD : 4'hC);
      enc_out_ready = 1;
      @(negedge clk);
      enc_out_ready = 0;
    end
    chk("R3", "no extra byte", enc_out_valid, 0);
    chk("R6", "ready after string", enc_in_ready, 1);
  endtask

  task automatic enc_bad(input string what, input int cnt, input logic [ND*4-1:0] dig);
    @(negedge clk);
    enc_in_valid = 1; enc_in_count = 6'(cnt); enc_in_neg = 0; enc_in_digits = dig;
    enc_out_ready = 1;
    @(negedge clk);
    enc_in_valid = 0;
    chk("R5", {what, " err pulse"}, enc_err, 1);
    chk("R5", {what, " no byte"}, enc_out_valid, 0);
    @(negedge clk);
    chk("R5", {what, " err one cycle"}, enc_err, 0);
    chk("R5", {what, " still no byte"}, enc_out_valid, 0);
    enc_out_ready = 0;
  endtask

  // decoder scenario on dbuf[0..nb-1]
  task automatic dec_case(input string tag, input int nb, input bit stall);
    bit e;
    logic [1:0] sgn;
    logic [3:0] sn;
    logic [ND*4-1:0] ed;
    int p;
    e = (nb > 16);
    ed = '0;
    sn = dbuf[nb-1][3:0];
    sgn = (sn == 4'hA || sn == 4'hC || sn == 4'hE || sn == 4'hF) ? 2'b10 :
          (sn == 4'hB || sn == 4'hD) ? 2'b11 : 2'b00;
    if (!sgn[1]) e = 1;
    for (int b = 0; b < nb; b++) begin
      if (dbuf[b][7:4] > 9) e = 1;
      if (b < nb - 1 && dbuf[b][3:0] > 9) e = 1;
    end
    if (!e) for (p = 0; p < 2 * nb - 1; p++)
      ed[p*4 +: 4] = (p % 2 == 0) ? dbuf[p/2][7:4] : dbuf[p/2][3:0];
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      if (b == 0) chk("R10", "dec_in_ready idle", dec_in_ready, 1);
      dec_in_valid = 1; dec_in_data = dbuf[b]; dec_in_last = (b == nb - 1);
    end
    @(negedge clk);
    dec_in_valid = 0; dec_in_last = 0;
    chk("R11", {tag, " result due"}, dec_out_valid, 1);
    chk(tag, "err", dec_out_err, e);
    chk(tag, "count", dec_out_count, e ? 0 : 2 * nb - 1);
    if (!e) begin
      chkv(tag, "digits", dec_out_digits, ed);
      chk("R8", "neg", dec_out_neg, sgn[0]);
    end
    if (stall) begin
      chk("R10", "dec_in_ready held", dec_in_ready, 0);
      @(negedge clk);
      chk("R10", "stall valid", dec_out_valid, 1);
      chk("R10", "stall count", dec_out_count, e ? 0 : 2 * nb - 1);
      chkv("R10", "stall digits", dec_out_digits, ed);
    end
    dec_out_ready = 1;
    @(negedge clk);
    dec_out_ready = 0;
    chk("R10", "result taken", dec_out_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [ND*4-1:0] d;
    repeat (3) @(negedge clk);
    chk("R6", "reset enc_out_valid", enc_out_valid, 0);
    chk("R10", "reset dec_out_valid", dec_out_valid, 0);
    chk("R5", "reset enc_err", enc_err, 0);
    rst_n = 1;

    // R1 odd count 5: 12345+ -> 12 34 5C
    d = '0; for (int i = 0; i < 5; i++) d[i*4 +: 4] = 4'(i + 1);
    enc_case("R1", 5, 0, d, 0);
    // R2 even count 4: 9876- -> 09 87 6D
    d = '0; d[3:0] = 9; d[7:4] = 8; d[11:8] = 7; d[15:12] = 6;
    enc_case("R2", 4, 1, d, 0);
    // R3 count 0 both signs
    enc_case("R3", 0, 0, '0, 0);
    enc_case("R3", 0, 1, '0, 0);
    // R6 full length with stall
    d = '0; for (int i = 0; i < 31; i++) d[i*4 +: 4] = 4'(i % 10);
    enc_case("R1", 31, 1, d, 1);
    // R5 digit above count ignored: count 2 digits 4,2, lane 5 = F
    d = '0; d[3:0] = 4; d[7:4] = 2; d[23:20] = 4'hF;
    enc_case("R5", 2, 0, d, 0);
    // R5 rejections
    d = '0; d[3:0] = 1; d[11:8] = 4'hA;
    enc_bad("bad digit", 3, d);
    enc_bad("count 32", 32, '0);

    // R7 decode 12 34 5C
    dbuf[0] = 8'h12; dbuf[1] = 8'h34; dbuf[2] = 8'h5C;
    dec_case("R7", 3, 0);
    dec_case("R10", 3, 1);
    // R7 padded negative 09 87 6D
    dbuf[0] = 8'h09; dbuf[1] = 8'h87; dbuf[2] = 8'h6D;
    dec_case("R7", 3, 0);
    // R8 alternate sign codes
    dbuf[0] = 8'h0B; dec_case("R8", 1, 0);
    dbuf[0] = 8'h7A; dec_case("R8", 1, 0);
    dbuf[0] = 8'h3F; dec_case("R8", 1, 0);
    dbuf[0] = 8'h1E; dec_case("R8", 1, 0);
    dbuf[0] = 8'h15; dec_case("R8", 1, 0);
    // R9 bad digit nibble and overlong string
    dbuf[0] = 8'hA1; dbuf[1] = 8'h2C; dec_case("R9", 2, 0);
    for (int b = 0; b < 16; b++) dbuf[b] = 8'h11;
    dbuf[15] = 8'h1C;
    dec_case("R7", 16, 0);
    dbuf[15] = 8'h11; dbuf[16] = 8'h2C;
    dec_case("R9", 17, 0);
    // recovery after error
    dbuf[0] = 8'h4D; dec_case("R9", 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule